// File: doc/BRIEF.md
# Video Slot Timer and CPU Access Arbiter

This block runs in the video clock domain and cuts each raster line into a fixed train of memory slots. Every slot is sixteen video cycles long and is split into three phases: two five-cycle windows in which the video fetch path reads memory, then a six-cycle window that belongs to the processor. A line is fifty-seven slots, or 912 video cycles. The block publishes the slot number, the cycle within the slot, one strobe per phase and a single-cycle end-of-line pulse.

The processor runs from its own, slower clock, roughly 3.56 times slower than the video clock and not phase-related to it. Its clock can only be stretched in whole half-cycles. When the processor's final bus cycle targets the shared video memory or the video registers, the arbiter samples the request at processor half-cycle boundaries. It holds the processor clock until a half-cycle starts with enough of the processor window left to contain it. It then issues a grant and releases the hold at the next half-cycle boundary. Bus cycles aimed elsewhere are never stretched.

Both clocks are modelled as enables on one fast clock: `vid_ce` marks a video cycle and `cpu_half_ce` marks a processor half-cycle boundary.

Top module: `vslot_arbiter`

## Requirements
- R1: While reset is applied and until the first enabled video cycle after release, slot_idx and slot_cyc are 0, ph_vrd0 is 1, ph_vrd1, ph_cpu, eol, cpu_grant and cpu_hold are 0.
- R2: slot_cyc advances by one on each clock with vid_ce high and stays put otherwise. Going from 15 to 0 increments slot_idx, and slot_idx wraps from 56 to 0.
- R3: eol is high for exactly one clock, the clock right after the enabled video cycle that wraps slot 56 cycle 15 to slot 0 cycle 0. That is once per 912 video cycles.
- R4: ph_vrd0 is high for slot_cyc 0..4, ph_vrd1 for 5..9 and ph_cpu for 10..15, and exactly one of the three is high at any time.
- R5: A request with cpu_vid low (a bus cycle that touches neither video memory nor video registers) never raises cpu_hold or cpu_grant.
- R6: A video request seen at a cpu_half_ce clock while slot_cyc is 10..14 (at least two window cycles left) is granted on the next clock with no hold at all.
- R7: A video request seen at a cpu_half_ce clock while slot_cyc is outside 10..14 raises cpu_hold on the next clock. The hold stays high while later cpu_half_ce clocks fall outside 10..14.
- R8: cpu_grant is a one-clock pulse. It follows a cpu_half_ce clock at which a video request was pending and slot_cyc was 10..14, and it only appears while ph_cpu is high.
- R9: After a grant, cpu_hold drops on the clock following the next cpu_half_ce clock.
- R10: Requests are only taken when the arbiter is idle. A request still present at the half-cycle boundary that releases a grant is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast common clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vid_ce | input | 1 | Video cycle enable |
| cpu_half_ce | input | 1 | Processor half-cycle boundary enable |
| cpu_req | input | 1 | Processor final bus cycle pending |
| cpu_vid | input | 1 | Pending cycle targets video memory or video registers |
| slot_idx | output | 6 | Slot number within the line, 0..56 |
| slot_cyc | output | 4 | Video cycle within the slot, 0..15 |
| ph_vrd0 | output | 1 | First video read phase |
| ph_vrd1 | output | 1 | Second video read phase |
| ph_cpu | output | 1 | Processor access window |
| eol | output | 1 | One-clock end-of-line pulse |
| cpu_grant | output | 1 | Processor access granted this half-cycle |
| cpu_hold | output | 1 | Stretch the processor clock |

## Verification
The slot counter and the arbiter meet when a half-cycle boundary coincides with the video enable that moves the slot counter. The fit decision must then use the cycle value before the advance, and the grant must still land inside the processor window. This is provoked by running the video enable every clock and also every other clock, while the half-cycle enable follows a 1.78-clock average cadence, so boundaries fall on every slot cycle, including 14 and 15 and the wrap of slot 56. A scoreboard model of the requirements predicts slot, phase, end-of-line, hold and grant on every clock, and the bench compares the model against the ports.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_GO   = 2'd2
  } arb_st_e;
endpackage

// File: rtl/vsa_slot_ctr.sv
module vsa_slot_ctr #(
  parameter int SLOTS  = 57,
  parameter int SLOT_W = 16,
  localparam int CYC_W = $clog2(SLOT_W),
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vid_ce,
  output logic [CYC_W-1:0] cyc,
  output logic [IDX_W-1:0] slot,
  output logic             eol
);
  localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(SLOT_W - 1);
  localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(SLOTS - 1);

  logic [CYC_W-1:0] cyc_d;
  logic [IDX_W-1:0] slot_d;
  logic             eol_d;

  always_comb begin
    cyc_d  = cyc;
    slot_d = slot;
    eol_d  = 1'b0;
    if (vid_ce) begin
      if (cyc == CYC_LAST) begin
        cyc_d = '0;
        if (slot == SLOT_LAST) begin
          slot_d = '0;
          eol_d  = 1'b1;
        end else begin
          slot_d = slot + 1'b1;
        end
      end else begin
        cyc_d = cyc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      slot <= '0;
      eol  <= 1'b0;
    end else begin
      cyc  <= cyc_d;
      slot <= slot_d;
      eol  <= eol_d;
    end
  end

  // R2
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_ce && cyc == CYC_LAST) |=> (cyc == '0));
  // R2
  ctr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_ce |=> ($stable(cyc) && $stable(slot)));
  // R3
  eol_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> (slot == '0 && cyc == '0));
  // R3
  eol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> !eol);
endmodule

// File: rtl/vsa_phase_dec.sv
module vsa_phase_dec #(
  parameter int SLOT_W  = 16,
  parameter int RD_LEN  = 5,
  parameter int FIT_CYC = 2,
  localparam int CYC_W  = $clog2(SLOT_W)
) (
  input  logic [CYC_W-1:0] cyc,
  output logic             ph_rd0,
  output logic             ph_rd1,
  output logic             ph_cpu,
  output logic             fit
);
  localparam logic [CYC_W-1:0] RD1_START = CYC_W'(RD_LEN);
  localparam logic [CYC_W-1:0] CPU_START = CYC_W'(2 * RD_LEN);
  localparam logic [CYC_W-1:0] FIT_LAST  = CYC_W'(SLOT_W - FIT_CYC);

  always_comb begin
    ph_rd0 = (cyc < RD1_START);
    ph_rd1 = (cyc >= RD1_START) && (cyc < CPU_START);
    ph_cpu = (cyc >= CPU_START);
    fit    = ph_cpu && (cyc <= FIT_LAST);
  end

  // R4
  phase_onehot_chk: assert final ($countones({ph_rd0, ph_rd1, ph_cpu}) == 1);
endmodule

// File: rtl/vsa_cpu_arb.sv
module vsa_cpu_arb
  import vsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_half_ce,
  input  logic cpu_req,
  input  logic cpu_vid,
  input  logic fit,
  output logic grant,
  output logic hold
);
  arb_st_e st, st_d;
  logic    grant_d, hold_d;

  always_comb begin
    st_d    = st;
    grant_d = 1'b0;
    hold_d  = hold;
    if (cpu_half_ce) begin
      unique case (st)
        ARB_IDLE: if (cpu_req && cpu_vid) begin
          if (fit) begin
            grant_d = 1'b1;
            st_d    = ARB_GO;
          end else begin
            hold_d = 1'b1;
            st_d   = ARB_WAIT;
          end
        end
        ARB_WAIT: if (fit) begin
          grant_d = 1'b1;
          st_d    = ARB_GO;
        end
        ARB_GO: begin
          hold_d = 1'b0;
          st_d   = ARB_IDLE;
        end
        default: st_d = ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ARB_IDLE;
      grant <= 1'b0;
      hold  <= 1'b0;
    end else begin
      st    <= st_d;
      grant <= grant_d;
      hold  <= hold_d;
    end
  end

  // R8
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  // R9
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(cpu_half_ce));
  // R5
  no_vid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARB_IDLE && cpu_half_ce && !cpu_vid) |=> !hold && !grant);
endmodule

// File: rtl/vslot_arbiter.sv
module vslot_arbiter #(
  parameter int SLOTS   = 57,
  parameter int SLOT_W  = 16,
  parameter int RD_LEN  = 5,
  parameter int FIT_CYC = 2,
  localparam int CYC_W  = $clog2(SLOT_W),
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vid_ce,
  input  logic             cpu_half_ce,
  input  logic             cpu_req,
  input  logic             cpu_vid,
  output logic [IDX_W-1:0] slot_idx,
  output logic [CYC_W-1:0] slot_cyc,
  output logic             ph_vrd0,
  output logic             ph_vrd1,
  output logic             ph_cpu,
  output logic             eol,
  output logic             cpu_grant,
  output logic             cpu_hold
);
  logic [1:0] rst_sync;
  logic       rst_n_s;
  logic       fit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  vsa_slot_ctr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n_s), .vid_ce(vid_ce),
    .cyc(slot_cyc), .slot(slot_idx), .eol(eol)
  );

  vsa_phase_dec #(.SLOT_W(SLOT_W), .RD_LEN(RD_LEN), .FIT_CYC(FIT_CYC)) u_dec (
    .cyc(slot_cyc), .ph_rd0(ph_vrd0), .ph_rd1(ph_vrd1), .ph_cpu(ph_cpu), .fit(fit)
  );

  vsa_cpu_arb u_arb (
    .clk(clk), .rst_n(rst_n_s), .cpu_half_ce(cpu_half_ce),
    .cpu_req(cpu_req), .cpu_vid(cpu_vid), .fit(fit),
    .grant(cpu_grant), .hold(cpu_hold)
  );

  // R8
  grant_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cpu_grant |-> ph_cpu);
  // R6
  fit_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_half_ce && fit && !cpu_hold && !cpu_grant && cpu_req && cpu_vid) |=> !cpu_hold);
endmodule

// File: tb/tb_vslot_arbiter.sv
`timescale 1ns/1ps
module tb_vslot_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       vid_ce, cpu_half_ce, cpu_req, cpu_vid;
  logic [5:0] slot_idx;
  logic [3:0] slot_cyc;
  logic       ph_vrd0, ph_vrd1, ph_cpu, eol, cpu_grant, cpu_hold;

  always #5 clk = ~clk;

  vslot_arbiter dut (
    .clk(clk), .rst_n(rst_n), .vid_ce(vid_ce), .cpu_half_ce(cpu_half_ce),
    .cpu_req(cpu_req), .cpu_vid(cpu_vid), .slot_idx(slot_idx), .slot_cyc(slot_cyc),
    .ph_vrd0(ph_vrd0), .ph_vrd1(ph_vrd1), .ph_cpu(ph_cpu), .eol(eol),
    .cpu_grant(cpu_grant), .cpu_hold(cpu_hold)
  );

  typedef struct packed {
    logic [5:0] slot;
    logic [3:0] cyc;
    logic       eol;
    logic       hold;
    logic       grant;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  int   eol_seen = 0;
  bit   done = 1'b0;

  // reference model state, built from the requirements
  int m_cyc = 0, m_slot = 0, m_st = 0;
  bit m_hold = 0, m_grant = 0, m_eol = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // driver: apply one clock of stimulus and push the predicted outputs
  task automatic drive(input bit vce, input bit hce, input bit rq, input bit vd);
    bit fit;
    @(negedge clk);
    vid_ce = vce; cpu_half_ce = hce; cpu_req = rq; cpu_vid = vd;
    fit = (m_cyc >= 10 && m_cyc <= 14);
    m_grant = 1'b0;
    if (hce) begin
      case (m_st)
        0: if (rq && vd) begin                 // R10 only idle takes requests
             if (fit) begin m_grant = 1'b1; m_st = 2; end   // R6
             else begin m_hold = 1'b1; m_st = 1; end        // R7
           end
        1: if (fit) begin m_grant = 1'b1; m_st = 2; end
        default: begin m_hold = 1'b0; m_st = 0; end         // R9
      endcase
    end
    m_eol = vce && m_cyc == 15 && m_slot == 56;
    if (vce) begin
      if (m_cyc == 15) begin m_cyc = 0; m_slot = (m_slot == 56) ? 0 : m_slot + 1; end
      else m_cyc = m_cyc + 1;
    end
    exp_q.push_back('{slot: 6'(m_slot), cyc: 4'(m_cyc), eol: m_eol, hold: m_hold, grant: m_grant});
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(slot_idx == e.slot && slot_cyc == e.cyc, "R2 slot/cyc",
            {slot_idx, slot_cyc}, {e.slot, e.cyc});
        chk(eol == e.eol, "R3 eol", eol, e.eol);
        if (eol) eol_seen++;
        chk(ph_vrd0 == (e.cyc < 5) && ph_vrd1 == (e.cyc >= 5 && e.cyc < 10) && ph_cpu == (e.cyc >= 10),
            "R4 phases", {ph_vrd0, ph_vrd1, ph_cpu},
            {(e.cyc < 5), (e.cyc >= 5 && e.cyc < 10), (e.cyc >= 10)});
        chk(cpu_hold == e.hold, "R7/R9/R5 hold", cpu_hold, e.hold);
        chk(cpu_grant == e.grant, "R6/R8/R10 grant", cpu_grant, e.grant);
      end
    end
  end

  initial begin
    #200us;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int acc = 0, gap = 3, hold_len = 0;
    bit rq = 0, vd = 0, keep = 0;
    logic [7:0] lfsr = 8'hA5;
    rst_n = 1'b0; vid_ce = 0; cpu_half_ce = 0; cpu_req = 0; cpu_vid = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(slot_idx == 0 && slot_cyc == 0, "R1 counters", {slot_idx, slot_cyc}, 0);
    chk(ph_vrd0 && !ph_vrd1 && !ph_cpu, "R1 phases", {ph_vrd0, ph_vrd1, ph_cpu}, 3'b100);
    chk(!eol && !cpu_grant && !cpu_hold, "R1 outputs", {eol, cpu_grant, cpu_hold}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(slot_idx == 0 && slot_cyc == 0 && !cpu_hold, "R1 after release",
        {slot_idx, slot_cyc, cpu_hold}, 0);

    for (int i = 0; i < 4200; i++) begin
      bit vce, hce;
      vce = (i < 2000) ? 1'b1 : (i < 3000) ? i[0] : (i % 3 != 0);
      acc += 100;
      hce = (acc >= 178);
      if (hce) acc -= 178;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (!rq) begin
        if (gap > 0) gap--;
        else begin
          rq = 1'b1; vd = (lfsr[1:0] != 2'b00); keep = lfsr[2]; hold_len = 4;  // R5 when vd=0
        end
      end else if (!vd) begin
        if (hold_len > 0) hold_len--; else begin rq = 0; gap = lfsr[2:0]; end
      end else if (m_st == 2) begin
        if (keep) keep = 1'b0;   // R10 request lingers into the releasing edge
        else begin rq = 0; gap = lfsr[3:0]; end
      end
      drive(vce, hce, rq, vd);
    end
    drive(0, 0, 0, 0);
    @(posedge clk); #3;
    // R3 two lines at one video cycle per clock, then more at reduced rate
    chk(eol_seen >= 3, "R3 eol count", eol_seen, 3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule